// File: doc/BRIEF.md
# Restartable Load-Multiple Sequencer

This block carries out a load-multiple operation. It fills a run of general registers from consecutive memory words. The run starts at index `first_idx_i` and ends at index `last_idx_i`. The indices form a ring of `NREG` entries, so the run may wrap past the top index back to zero. A one-cycle `start_i` captures the two indices, the base address and a lane mode. The block then issues reads one at a time on its memory request port and writes each result through a single register-file write port. That port carries a two-bit half mask.

The reads are ordered so that a translation fault can never leave the register file partly updated. The word at the base address and the word at the far end of the range are fetched and held first. No register is written until both have returned without a fault. A fault on either of these two probes ends the operation with a one-cycle `fault_o` and the faulting address, and no register is written. The operation can then be restarted unchanged. After both probes succeed, the two end registers are committed and the interior registers are loaded in ascending ring order. The interior reads cannot fault, because the two probes already covered both ends of the range.

Top module: `lm_seq`

## Requirements
- R1: When the first and last index are equal, exactly one read is issued, at the base address. That register is then written once, and `done_o` pulses.
- R2: When the indices differ, the first two reads go to the base address and to base + stride × ((last − first) mod NREG), in that order. No register write occurs before both responses have arrived.
- R3: The stride is 4 bytes in modes 0 and 1 and 8 bytes in mode 2.
- R4: A response with `rd_fault_i` high on either probe read ends the operation. No register is written, `fault_o` pulses for one cycle without `done_o`, and `fault_addr_o` holds the address of the faulting read.
- R5: After both probes succeed, the first register receives the first word and then the last register receives the last word.
- R6: When the last index is (first + 1) mod NREG, the operation completes after exactly the two probe reads.
- R7: Otherwise, the interior registers (first+1) through (last−1) are read and written in ascending ring order, at addresses base + stride × k for k = 1, 2, and so on.
- R8: Lane modes and masks. In mode 0, the word is `rd_data_i[31:0]`; it goes to bits 31:0 with mask 2'b01, and bits 63:32 are kept. In mode 1, the same word goes to bits 63:32 with mask 2'b10, and bits 31:0 are kept. In mode 2, all 64 bits are written with mask 2'b11. Mask bit 0 selects bits 31:0 and bit 1 selects bits 63:32.
- R9: Index arithmetic wraps modulo NREG, so a range whose last index is numerically below the first covers the wrapped registers. This includes the full ring, where last = first − 1.
- R10: While `busy_o` is high, `start_i` is ignored. Addresses come only from the values captured at the accepted start.
- R11: At most one read is outstanding at any time. `done_o` is a single-cycle pulse and is never high together with `fault_o`.
- R12: One cycle after a clock with `rst` high, `busy_o`, `rd_req_o`, `wr_en_o`, `done_o` and `fault_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| first_idx_i | input | 4 | First register index of the range |
| last_idx_i | input | 4 | Last register index of the range |
| base_i | input | AW | Byte address of the first word |
| mode_i | input | 2 | 0: low half, 1: high half, 2: full 64-bit |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DW | Read response data |
| rd_fault_i | input | 1 | Read response carries a translation fault |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 4 | Register index to write |
| wr_data_o | output | DW | Write data, already placed in its lane |
| wr_mask_o | output | 2 | Half-word write mask |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_addr_o | output | AW | Address of the faulting read |

## Verification
Several rules are checked by the assertions on every cycle. These are: one read outstanding at a time, no write before the probe responses have arrived, a mask that matches the captured mode, fault and done never together with each other or with a write, and the state after reset. Other behaviour can only be shown by the bench scenarios. This covers the exact address of every read, the order of register commits across a wrapped range, lane merging into previously held register contents, the register file left unchanged after a fault on either probe, and a start pulse during an operation having no effect. The bench checks these by comparing each request and write against a behavioural model, and the whole register file after each operation.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    LM_LO   = 2'd0,
    LM_HI   = 2'd1,
    LM_FULL = 2'd2
  } lm_mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WAIT  = 2'd1,
    S_WLAST = 2'd2
  } lm_state_e;

  typedef enum logic [1:0] {
    P_FIRST = 2'd0,
    P_LAST  = 2'd1,
    P_MID   = 2'd2
  } lm_phase_e;
endpackage

// File: rtl/lm_addr_gen.sv
module lm_addr_gen
  import lm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int IW = 4
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] span,
  input  logic [1:0]    mode,
  output logic [AW-1:0] stride,
  output logic [AW-1:0] last_addr
);
  localparam int WIDE_B = DW / 8;
  localparam int HALF_B = DW / 16;

  logic narrow;
  assign narrow    = (mode == LM_LO) || (mode == LM_HI);
  assign stride    = narrow ? AW'(HALF_B) : AW'(WIDE_B);
  assign last_addr = base + (AW'(span) * stride);
endmodule

// File: rtl/lm_lane_pack.sv
module lm_lane_pack
  import lm_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] data,
  output logic [1:0]    mask
);
  localparam int HW = DW / 2;

  always_comb begin
    case (mode)
      LM_LO: begin
        data = {{HW{1'b0}}, word[HW-1:0]};
        mask = 2'b01;
      end
      LM_HI: begin
        data = {word[HW-1:0], {HW{1'b0}}};
        mask = 2'b10;
      end
      default: begin
        data = word;
        mask = 2'b11;
      end
    endcase
  end
endmodule

// File: rtl/lm_seq.sv
module lm_seq
  import lm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [$clog2(NREG)-1:0] first_idx_i,
  input  logic [$clog2(NREG)-1:0] last_idx_i,
  input  logic [AW-1:0]           base_i,
  input  logic [1:0]              mode_i,
  output logic                    busy_o,
  output logic                    rd_req_o,
  output logic [AW-1:0]           rd_addr_o,
  input  logic                    rd_ack_i,
  input  logic [DW-1:0]           rd_data_i,
  input  logic                    rd_fault_i,
  output logic                    wr_en_o,
  output logic [$clog2(NREG)-1:0] wr_idx_o,
  output logic [DW-1:0]           wr_data_o,
  output logic [1:0]              wr_mask_o,
  output logic                    done_o,
  output logic                    fault_o,
  output logic [AW-1:0]           fault_addr_o
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] ONE = IW'(1);

  lm_state_e     state_q;
  lm_phase_e     phase_q;
  logic [IW-1:0] r1_q, r3_q, cur_q;
  logic [AW-1:0] base_q;
  logic [1:0]    mode_q;
  logic [DW-1:0] first_q, last_q;

  logic [AW-1:0] stride, last_addr;
  logic [IW-1:0] span, r1_nxt, r3_prv;
  logic [DW-1:0] pack_in, pack_data;
  logic [1:0]    pack_mask;

  assign span   = r3_q - r1_q;
  assign r1_nxt = r1_q + ONE;
  assign r3_prv = r3_q - ONE;
  assign busy_o = (state_q != S_IDLE);

  lm_addr_gen #(.AW(AW), .DW(DW), .IW(IW)) u_addr (
    .base(base_q), .span(span), .mode(mode_q),
    .stride(stride), .last_addr(last_addr)
  );

  // Word to commit: buffered last probe, buffered first probe, or live data.
  always_comb begin
    if (state_q == S_WLAST)      pack_in = last_q;
    else if (phase_q == P_LAST)  pack_in = first_q;
    else                         pack_in = rd_data_i;
  end

  lm_lane_pack #(.DW(DW)) u_pack (
    .mode(mode_q), .word(pack_in), .data(pack_data), .mask(pack_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      phase_q      <= P_FIRST;
      r1_q         <= '0;
      r3_q         <= '0;
      cur_q        <= '0;
      base_q       <= '0;
      mode_q       <= '0;
      first_q      <= '0;
      last_q       <= '0;
      rd_req_o     <= 1'b0;
      rd_addr_o    <= '0;
      wr_en_o      <= 1'b0;
      wr_idx_o     <= '0;
      wr_data_o    <= '0;
      wr_mask_o    <= '0;
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      rd_req_o <= 1'b0;
      wr_en_o  <= 1'b0;
      done_o   <= 1'b0;
      fault_o  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            r1_q      <= first_idx_i;
            r3_q      <= last_idx_i;
            base_q    <= base_i;
            mode_q    <= mode_i;
            rd_req_o  <= 1'b1;
            rd_addr_o <= base_i;
            phase_q   <= P_FIRST;
            state_q   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (rd_ack_i) begin
            case (phase_q)
              P_FIRST: begin
                if (rd_fault_i) begin
                  fault_o      <= 1'b1;
                  fault_addr_o <= rd_addr_o;
                  state_q      <= S_IDLE;
                end else if (r1_q == r3_q) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= r1_q;
                  wr_data_o <= pack_data;
                  wr_mask_o <= pack_mask;
                  done_o    <= 1'b1;
                  state_q   <= S_IDLE;
                end else begin
                  first_q   <= rd_data_i;
                  rd_req_o  <= 1'b1;
                  rd_addr_o <= last_addr;
                  phase_q   <= P_LAST;
                end
              end
              P_LAST: begin
                if (rd_fault_i) begin
                  fault_o      <= 1'b1;
                  fault_addr_o <= rd_addr_o;
                  state_q      <= S_IDLE;
                end else begin
                  last_q    <= rd_data_i;
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= r1_q;
                  wr_data_o <= pack_data;
                  wr_mask_o <= pack_mask;
                  state_q   <= S_WLAST;
                end
              end
              default: begin
                // Interior reads: both range ends were already proven.
                wr_en_o   <= 1'b1;
                wr_idx_o  <= cur_q;
                wr_data_o <= pack_data;
                wr_mask_o <= pack_mask;
                if (cur_q == r3_prv) begin
                  done_o  <= 1'b1;
                  state_q <= S_IDLE;
                end else begin
                  cur_q     <= cur_q + ONE;
                  rd_req_o  <= 1'b1;
                  rd_addr_o <= rd_addr_o + stride;
                end
              end
            endcase
          end
        end
        default: begin
          wr_en_o   <= 1'b1;
          wr_idx_o  <= r3_q;
          wr_data_o <= pack_data;
          wr_mask_o <= pack_mask;
          if (r1_nxt == r3_q) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cur_q     <= r1_nxt;
            rd_req_o  <= 1'b1;
            rd_addr_o <= base_q + stride;
            phase_q   <= P_MID;
            state_q   <= S_WAIT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lm_seq_chk.sv
module lm_seq_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [IW-1:0] first_idx_i,
  input logic [IW-1:0] last_idx_i,
  input logic [1:0]    mode_i,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic          rd_ack_i,
  input logic          rd_fault_i,
  input logic          wr_en_o,
  input logic [1:0]    wr_mask_o,
  input logic          done_o,
  input logic          fault_o
);
  logic       outst;
  logic [1:0] acks;
  logic       multi;
  logic [1:0] cmode;
  logic [1:0] exp_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= 1'b0;
      acks  <= 2'd0;
      multi <= 1'b0;
      cmode <= 2'd0;
    end else begin
      if (start_i && !busy_o) begin
        acks  <= 2'd0;
        multi <= (first_idx_i != last_idx_i);
        cmode <= mode_i;
      end else if (rd_ack_i && acks != 2'd3) begin
        acks <= acks + 2'd1;
      end
      if (rd_req_o)      outst <= 1'b1;
      else if (rd_ack_i) outst <= 1'b0;
    end
  end

  assign exp_mask = (cmode == 2'd0) ? 2'b01 : (cmode == 2'd1) ? 2'b10 : 2'b11;

  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> !outst);
  // R2
  probes_first_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (acks >= (multi ? 2'd2 : 2'd1)));
  // R4
  fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!wr_en_o && !done_o));
  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $past(rd_ack_i && rd_fault_i));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8
  lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_mask_o == exp_mask));
  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !rd_req_o && !wr_en_o && !done_o && !fault_o));
endmodule

bind lm_seq lm_seq_chk #(.IW($clog2(NREG))) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .first_idx_i(first_idx_i), .last_idx_i(last_idx_i), .mode_i(mode_i),
  .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
  .rd_fault_i(rd_fault_i), .wr_en_o(wr_en_o), .wr_mask_o(wr_mask_o),
  .done_o(done_o), .fault_o(fault_o)
);

// File: tb/test_lm_seq.sv
module test_lm_seq;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [3:0]    first_idx_i = '0, last_idx_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [1:0]    mode_i = '0;
  logic          busy_o, rd_req_o, wr_en_o, done_o, fault_o;
  logic [AW-1:0] rd_addr_o, fault_addr_o;
  logic          rd_ack_i = 1'b0, rd_fault_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0, wr_data_o;
  logic [3:0]    wr_idx_o;
  logic [1:0]    wr_mask_o;

  always #5 clk = ~clk;

  lm_seq #(.AW(AW), .DW(DW), .NREG(16)) i_lm_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .first_idx_i(first_idx_i),
    .last_idx_i(last_idx_i), .base_i(base_i), .mode_i(mode_i), .busy_o(busy_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .rd_fault_i(rd_fault_i), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o),
    .done_o(done_o), .fault_o(fault_o), .fault_addr_o(fault_addr_o)
  );

  int errors = 0, checks = 0, cyc = 0;
  logic [DW-1:0] regs [16];
  logic [DW-1:0] exp_regs [16];
  logic [AW-1:0] exp_rd[$];
  string         exp_rd_tag[$];
  int            exp_wi[$];
  int  lat = 1, pend = 0, cnt = 0, acked = 0, need = 1;
  logic [AW-1:0] paddr = '0;
  bit  ended = 0, end_fault = 0, end_both = 0;
  logic [AW-1:0] end_faddr = '0;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_0F0F, a * 32'd2654435761 + 32'd17};
  endfunction
  function automatic bit is_fault(input logic [AW-1:0] a);
    return (a >= 32'h8000) && (a < 32'h9000);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Memory responder, register-file mirror and per-clock comparison.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cyc > 100000) begin
        chk(0, "R11", "watchdog expired", 64'(cyc), 64'd100000);
        finish_run();
      end
      rd_ack_i = 1'b0;
      rd_fault_i = 1'b0;
      if (pend != 0) begin
        cnt--;
        if (cnt == 0) begin
          rd_ack_i = 1'b1;
          rd_data_i = mem_word(paddr);
          rd_fault_i = is_fault(paddr);
          pend = 0;
          acked++;
        end
      end
      if (rd_req_o) begin
        chk(pend == 0, "R11", "request while outstanding", 64'(pend), 64'd0);
        if (exp_rd.size() > 0) begin
          chk(rd_addr_o == exp_rd[0], exp_rd_tag[0], "read address",
              64'(rd_addr_o), 64'(exp_rd[0]));
          void'(exp_rd.pop_front());
          void'(exp_rd_tag.pop_front());
        end else begin
          chk(0, "R6", "unexpected extra read", 64'(rd_addr_o), 64'd0);
        end
        pend = 1;
        cnt = lat;
        paddr = rd_addr_o;
      end
      if (wr_en_o) begin
        chk(acked >= need, "R2", "write before probe responses", 64'(acked), 64'(need));
        if (exp_wi.size() > 0) begin
          chk(int'(wr_idx_o) == exp_wi[0], "R5", "write index order",
              64'(wr_idx_o), 64'(exp_wi[0]));
          void'(exp_wi.pop_front());
        end else begin
          chk(0, "R4", "unexpected write", 64'(wr_idx_o), 64'd0);
        end
        if (wr_mask_o[0]) regs[wr_idx_o][31:0]  = wr_data_o[31:0];
        if (wr_mask_o[1]) regs[wr_idx_o][63:32] = wr_data_o[63:32];
      end
      if (done_o || fault_o) begin
        ended = 1;
        end_fault = fault_o;
        end_both = done_o && fault_o;
        end_faddr = fault_addr_o;
      end
    end
  end

  task automatic run_op(input int a, input int b, input logic [AW-1:0] base,
                        input int mode, input int l, input string tag,
                        input bit poke);
    int span, stride, k;
    logic [AW-1:0] last, faddr;
    bit xf;
    logic [DW-1:0] w;
    span = (b - a) & 15;
    stride = (mode == 2) ? 8 : 4;
    last = base + AW'(stride * span);
    for (int i = 0; i < 16; i++) exp_regs[i] = regs[i];
    xf = 0;
    faddr = '0;
    exp_rd.push_back(base); exp_rd_tag.push_back(span == 0 ? "R1" : "R2");
    if (is_fault(base)) begin
      xf = 1; faddr = base;
    end else if (span != 0) begin
      exp_rd.push_back(last); exp_rd_tag.push_back("R3");
      if (is_fault(last)) begin
        xf = 1; faddr = last;
      end
    end
    if (!xf) begin
      exp_wi.push_back(a);
      if (span != 0) exp_wi.push_back(b);
      for (k = 1; k < span; k++) begin
        exp_rd.push_back(base + AW'(stride * k)); exp_rd_tag.push_back("R7");
        exp_wi.push_back((a + k) & 15);
      end
      for (k = 0; k <= span; k++) begin
        w = mem_word(base + AW'(stride * k));
        case (mode)
          0: exp_regs[(a + k) & 15][31:0]  = w[31:0];
          1: exp_regs[(a + k) & 15][63:32] = w[31:0];
          default: exp_regs[(a + k) & 15] = w;
        endcase
      end
    end
    lat = l;
    acked = 0;
    need = (span == 0) ? 1 : 2;
    ended = 0;
    @(negedge clk);
    start_i = 1'b1; first_idx_i = 4'(a); last_idx_i = 4'(b);
    base_i = base; mode_i = 2'(mode);
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk(busy_o, "R10", "busy during operation", 64'(busy_o), 64'd1);
      start_i = 1'b1; first_idx_i = 4'd0; last_idx_i = 4'd15;
      base_i = 32'h9000; mode_i = 2'd2;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!ended) @(negedge clk);
    @(negedge clk);
    chk(end_fault == xf, xf ? "R4" : tag, "fault vs done outcome", 64'(end_fault), 64'(xf));
    chk(!end_both, "R11", "done and fault together", 64'(end_both), 64'd0);
    if (xf) chk(end_faddr == faddr, "R4", "fault address", 64'(end_faddr), 64'(faddr));
    chk(exp_rd.size() == 0, tag, "reads missing", 64'(exp_rd.size()), 64'd0);
    chk(exp_wi.size() == 0, tag, "writes missing", 64'(exp_wi.size()), 64'd0);
    chk(!busy_o, "R11", "idle after end", 64'(busy_o), 64'd0);
    for (int i = 0; i < 16; i++)
      chk(regs[i] === exp_regs[i], xf ? "R4" : tag, $sformatf("register %0d", i),
          regs[i], exp_regs[i]);
    exp_rd.delete(); exp_rd_tag.delete(); exp_wi.delete();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = {32'hC0DE_0000 | 32'(i), 32'h0000_1000 + 32'(i)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(!busy_o && !rd_req_o && !wr_en_o && !done_o && !fault_o, "R12",
        "outputs after reset", {59'd0, busy_o, rd_req_o, wr_en_o, done_o, fault_o}, 64'd0);
    run_op(5, 5, 32'h100, 2, 1, "R1", 0);
    run_op(3, 4, 32'h2000, 0, 2, "R6", 0);
    run_op(14, 2, 32'h3010, 1, 3, "R9", 0);
    run_op(0, 15, 32'h4000, 2, 1, "R7", 0);
    run_op(7, 6, 32'h5000, 0, 2, "R9", 0);
    run_op(9, 12, 32'h6000, 1, 1, "R8", 0);
    run_op(10, 13, 32'h6800, 2, 2, "R3", 0);
    run_op(2, 9, 32'h8000, 2, 2, "R4", 0);
    run_op(2, 9, 32'h7FF0, 2, 1, "R4", 0);
    run_op(12, 11, 32'h7FE0, 0, 3, "R4", 0);
    run_op(4, 4, 32'h8100, 1, 1, "R4", 0);
    run_op(1, 6, 32'h1200, 1, 3, "R10", 1);
    run_op(8, 8, 32'h1300, 0, 2, "R8", 0);
    finish_run();
  end
endmodule